// File: doc/BRIEF.md
# NAND Command Front-End

This block is the device-side command interpreter of a NAND flash model. The host presents bytes on an I/O bus together with a one-cycle write strobe. A byte counts as a command when the command-latch input is high, and as an address byte when the address-latch input is high. The block follows the multi-byte sequences for page read, page program and block erase. It reports each operation that begins to a back end as a one-cycle start pulse, an operation code and the collected address. An active-low ready/busy output is held low for a number of cycles that the back end programs separately for each kind of operation.

The same byte-wide output answers two kinds of query. An identification query returns a fixed four-byte signature, one byte per read strobe. A status query places a status byte on the bus, and the byte stays there until the next command that the block accepts. Bit 0 of the status byte holds the pass/fail outcome of the most recent completed program or erase. A reset command aborts any operation in progress and starts its own busy interval.

Top module: `nand_cmd_frontend`

## Requirements
- R1: After reset, `rb_n` is 1, `io_out` is 00h, `op_start` and `op_abort` are 0, and the status fail bit is 0.
- R2: Command 90h followed by one address cycle enters identification output. `io_out` then shows ECh, 76h, A5h and C0h in turn, each read strobe advancing one byte. After the fourth byte it shows 00h. Between 90h and its address cycle, `io_out` is 00h.
- R3: Command 70h enters status output. `io_out` then shows {wp_n, ready, 5'b0, fail}, where ready is 1 when not busy. Read strobes leave it unchanged, and it stays in force until another command is accepted.
- R4: The fail bit takes the value of `op_fail` in the last busy cycle of a program or erase. A read leaves the fail bit alone, and an accepted reset command clears it to 0.
- R5: The sequence 80h, four address bytes (the first goes to `op_addr[7:0]`), any data cycles, then 10h pulses `op_start` with `op_kind`=2 and the address. `rb_n` is low from the next cycle for `t_prog` cycles, or for 1 cycle when `t_prog` is 0. `op_kind` codes are 1 read, 2 program, 3 erase, 4 reset.
- R6: The sequence 60h, three address bytes, then D0h starts an erase with `op_kind`=3. `op_addr` carries the three bytes in [23:0] and 0 above them, and busy lasts `t_erase` cycles.
- R7: 00h followed by four address bytes starts a read with `op_kind`=3'd1 on the fourth address byte, with a busy time of `t_read` cycles.
- R8: FFh accepted while ready starts a reset (`op_kind`=4) with a busy time of `t_reset` cycles, and `op_abort` stays 0.
- R9: FFh accepted while busy pulses `op_abort` together with `op_start` (`op_kind`=4) and replaces the remaining busy time with `t_reset` cycles. The aborted operation records no fail result.
- R10: While `rb_n` is low, only 70h and FFh are accepted. All other commands and all address cycles are ignored.
- R11: A command byte outside {00h, 10h, 60h, 70h, 80h, 90h, D0h, FFh} is dropped, and so is 10h or D0h outside its sequence. Neither changes the output mode, the identification position or the operation state.
- R12: A command or address cycle whose `io_in[15:8]` is not zero is ignored. A cycle with both latch inputs high is also ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cle | input | 1 | Command latch qualifier |
| ale | input | 1 | Address latch qualifier |
| we_stb | input | 1 | One-cycle write strobe |
| re_stb | input | 1 | One-cycle read strobe |
| io_in | input | BUS_W | Host bus input; the low byte carries commands and addresses |
| wp_n | input | 1 | Write-protect level, 1 = not protected |
| t_read | input | CNT_W | Busy cycles for a read |
| t_prog | input | CNT_W | Busy cycles for a program |
| t_erase | input | CNT_W | Busy cycles for an erase |
| t_reset | input | CNT_W | Busy cycles for a reset |
| op_fail | input | 1 | Back-end result of the current program or erase |
| io_out | output | 8 | Identification or status byte |
| rb_n | output | 1 | Ready/busy, low while busy |
| op_start | output | 1 | One-cycle pulse when an operation starts |
| op_kind | output | 3 | Code of the operation that started |
| op_addr | output | 8*ADDR_BYTES | Collected address bytes |
| op_abort | output | 1 | Pulse when a reset cuts a busy operation short |

## Verification
Two functions can land on the same clock edge: the completion of a program, which captures `op_fail` into the status bit, and an incoming reset command, which both aborts and clears that bit. The bench programs a two-cycle program with a failing result and times an FFh so that it is accepted in the final busy cycle. It expects an abort pulse, a fresh reset interval and a clear fail bit afterwards. A second overlap places 70h inside a busy window; there the status byte must show ready at 0 and the previous fail value. A query command written during that window must leave status mode in force.

// File: rtl/nand_fe_pkg.sv
// Package: shared types, command codes and the identification signature
// for the NAND command front-end.
package nand_fe_pkg;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_READ  = 3'd1,
        OP_PROG  = 3'd2,
        OP_ERASE = 3'd3,
        OP_RESET = 3'd4
    } op_kind_t;

    typedef enum logic [1:0] {
        OUT_NONE   = 2'd0,
        OUT_ID     = 2'd1,
        OUT_STATUS = 2'd2
    } out_mode_t;

    localparam logic [7:0] CMD_READ     = 8'h00;
    localparam logic [7:0] CMD_PG_SETUP = 8'h80;
    localparam logic [7:0] CMD_PG_GO    = 8'h10;
    localparam logic [7:0] CMD_ER_SETUP = 8'h60;
    localparam logic [7:0] CMD_ER_GO    = 8'hD0;
    localparam logic [7:0] CMD_STATUS   = 8'h70;
    localparam logic [7:0] CMD_IDENT    = 8'h90;
    localparam logic [7:0] CMD_RESET    = 8'hFF;

    localparam int ID_LEN = 4;

    // Signature byte at a given position; 00h past the end.
    function automatic logic [7:0] id_byte(input int idx);
        case (idx)
            0:       return 8'hEC;
            1:       return 8'h76;
            2:       return 8'hA5;
            3:       return 8'hC0;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/nand_seq_decode.sv
// Module: nand_seq_decode
// Qualifies write cycles as command or address cycles, tracks the multi-byte
// sequences for read, program, erase and identification, and collects address
// bytes. It emits one-cycle requests that the rest of the front-end acts on.
// Assumes: we_stb is a single-cycle pulse; busy is the registered busy state.
module nand_seq_decode
    import nand_fe_pkg::*;
#(
    parameter int BUS_W      = 16,
    parameter int ADDR_BYTES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cle,
    input  logic                    ale,
    input  logic                    we_stb,
    input  logic [BUS_W-1:0]        io_in,
    input  logic                    busy,
    output logic                    st_req,
    output logic                    other_req,
    output logic                    id_go,
    output logic                    op_go,
    output op_kind_t                go_kind,
    output logic [8*ADDR_BYTES-1:0] addr
);

    localparam int AW       = $clog2(ADDR_BYTES + 1);
    localparam int ER_BYTES = ADDR_BYTES - 1;

    typedef enum logic [2:0] {
        PH_IDLE, PH_ID_ADDR, PH_RD_ADDR, PH_PG_ADDR, PH_PG_DATA, PH_ER_ADDR, PH_ER_CONF
    } phase_t;

    phase_t       phase;
    logic [AW-1:0] acnt;
    logic          upper_ok;
    logic [7:0]    byte_in;
    logic          cmd_cyc, adr_cyc;
    logic          rst_req, rd_setup, pg_setup, er_setup, id_setup, pg_go, er_go;
    logic          rd_last, pg_last, er_last;

    // Upper byte check exists only on a bus wider than one byte.
    if (BUS_W > 8) begin : g_wide
        assign upper_ok = ~|io_in[BUS_W-1:8];
    end else begin : g_narrow
        assign upper_ok = 1'b1;
    end

    assign byte_in = io_in[7:0];

    // Cycle qualification and command/address decode.
    always_comb begin
        cmd_cyc   = we_stb & cle & ~ale & upper_ok;
        adr_cyc   = we_stb & ale & ~cle & upper_ok & ~busy;
        st_req    = cmd_cyc && byte_in == CMD_STATUS;
        rst_req   = cmd_cyc && byte_in == CMD_RESET;
        rd_setup  = cmd_cyc && !busy && byte_in == CMD_READ;
        pg_setup  = cmd_cyc && !busy && byte_in == CMD_PG_SETUP;
        er_setup  = cmd_cyc && !busy && byte_in == CMD_ER_SETUP;
        id_setup  = cmd_cyc && !busy && byte_in == CMD_IDENT;
        pg_go     = cmd_cyc && !busy && byte_in == CMD_PG_GO && phase == PH_PG_DATA;
        er_go     = cmd_cyc && !busy && byte_in == CMD_ER_GO && phase == PH_ER_CONF;
        other_req = rst_req | rd_setup | pg_setup | er_setup | id_setup | pg_go | er_go;
        rd_last   = adr_cyc && phase == PH_RD_ADDR && acnt == AW'(ADDR_BYTES - 1);
        pg_last   = adr_cyc && phase == PH_PG_ADDR && acnt == AW'(ADDR_BYTES - 1);
        er_last   = adr_cyc && phase == PH_ER_ADDR && acnt == AW'(ER_BYTES - 1);
        id_go     = adr_cyc && phase == PH_ID_ADDR;
        op_go     = rst_req | rd_last | pg_go | er_go;
        if (rst_req)      go_kind = OP_RESET;
        else if (rd_last) go_kind = OP_READ;
        else if (pg_go)   go_kind = OP_PROG;
        else if (er_go)   go_kind = OP_ERASE;
        else              go_kind = OP_NONE;
    end

    // Sequence phase, address byte counter and address collection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            acnt  <= '0;
            addr  <= '0;
        end else if (rst_req || pg_go || er_go) begin
            phase <= PH_IDLE;
            acnt  <= '0;
        end else if (rd_setup || pg_setup || er_setup || id_setup) begin
            acnt <= '0;
            addr <= '0;
            if (rd_setup)      phase <= PH_RD_ADDR;
            else if (pg_setup) phase <= PH_PG_ADDR;
            else if (er_setup) phase <= PH_ER_ADDR;
            else               phase <= PH_ID_ADDR;
        end else if (adr_cyc) begin
            case (phase)
                PH_RD_ADDR, PH_PG_ADDR, PH_ER_ADDR: begin
                    for (int b = 0; b < ADDR_BYTES; b++) begin
                        if (acnt == AW'(b)) addr[8*b +: 8] <= byte_in;
                    end
                    acnt <= acnt + AW'(1);
                    if (rd_last)      phase <= PH_IDLE;
                    else if (pg_last) phase <= PH_PG_DATA;
                    else if (er_last) phase <= PH_ER_CONF;
                end
                PH_ID_ADDR: phase <= PH_IDLE;
                default:    phase <= phase;
            endcase
        end
    end

endmodule

// File: rtl/nand_busy_timer.sv
// Module: nand_busy_timer
// Down-counter that models the busy interval of the running operation and
// holds the pass/fail bit. A start always reloads, so a reset start cuts a
// running interval short. Assumes start is a one-cycle request.
module nand_busy_timer
    import nand_fe_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  op_kind_t         kind_in,
    input  logic [CNT_W-1:0] load_val,
    input  logic             op_fail,
    output logic             busy,
    output logic             fail
);

    logic [CNT_W-1:0] cnt;
    op_kind_t         cur;

    assign busy = (cnt != '0);

    // Interval count, current operation and fail capture on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            cur  <= OP_NONE;
            fail <= 1'b0;
        end else if (start) begin
            cnt <= (load_val == '0) ? CNT_W'(1) : load_val;
            cur <= kind_in;
            if (kind_in == OP_RESET) fail <= 1'b0;
        end else if (busy) begin
            cnt <= cnt - CNT_W'(1);
            if (cnt == CNT_W'(1) && (cur == OP_PROG || cur == OP_ERASE)) fail <= op_fail;
        end
    end

endmodule

// File: rtl/nand_resp_mux.sv
// Module: nand_resp_mux
// Holds the output mode (none, identification, status) and the signature
// position, and forms the byte on io_out. Assumes st_req, other_req and id_go
// are never high in the same cycle.
module nand_resp_mux
    import nand_fe_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      st_req,
    input  logic      other_req,
    input  logic      id_go,
    input  logic      re_stb,
    input  logic      wp_n,
    input  logic      busy,
    input  logic      fail,
    output out_mode_t mode,
    output logic [7:0] io_out
);

    localparam int IW = $clog2(ID_LEN + 1);

    logic [IW-1:0] idx;

    // Mode selection and signature position advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= OUT_NONE;
            idx  <= '0;
        end else if (st_req) begin
            mode <= OUT_STATUS;
        end else if (id_go) begin
            mode <= OUT_ID;
            idx  <= '0;
        end else if (other_req) begin
            mode <= OUT_NONE;
        end else if (re_stb && mode == OUT_ID && idx != IW'(ID_LEN)) begin
            idx <= idx + IW'(1);
        end
    end

    // Output byte for the current mode.
    always_comb begin
        case (mode)
            OUT_ID:     io_out = id_byte(int'(idx));
            OUT_STATUS: io_out = {wp_n, ~busy, 5'b0, fail};
            default:    io_out = 8'h00;
        endcase
    end

endmodule

// File: rtl/nand_cmd_frontend.sv
// Module: nand_cmd_frontend (top)
// Command front-end for a NAND flash model: decodes command and address
// cycles, answers identification and status reads, drives ready/busy and
// reports started operations to a back end. Assumes strobes are single-cycle
// pulses synchronous to clk; reset is synchronous and active low.
module nand_cmd_frontend
    import nand_fe_pkg::*;
#(
    parameter int BUS_W      = 16,
    parameter int ADDR_BYTES = 4,
    parameter int CNT_W      = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cle,
    input  logic                    ale,
    input  logic                    we_stb,
    input  logic                    re_stb,
    input  logic [BUS_W-1:0]        io_in,
    input  logic                    wp_n,
    input  logic [CNT_W-1:0]        t_read,
    input  logic [CNT_W-1:0]        t_prog,
    input  logic [CNT_W-1:0]        t_erase,
    input  logic [CNT_W-1:0]        t_reset,
    input  logic                    op_fail,
    output logic [7:0]              io_out,
    output logic                    rb_n,
    output logic                    op_start,
    output logic [2:0]              op_kind,
    output logic [8*ADDR_BYTES-1:0] op_addr,
    output logic                    op_abort
);

    logic             st_req, other_req, id_go, op_go, busy, fail;
    op_kind_t         go_kind;
    logic [CNT_W-1:0] load_val;
    out_mode_t        out_mode;

    nand_seq_decode #(.BUS_W(BUS_W), .ADDR_BYTES(ADDR_BYTES)) u_dec (
        .clk(clk), .rst_n(rst_n), .cle(cle), .ale(ale), .we_stb(we_stb),
        .io_in(io_in), .busy(busy), .st_req(st_req), .other_req(other_req),
        .id_go(id_go), .op_go(op_go), .go_kind(go_kind), .addr(op_addr)
    );

    // Busy length for the operation being started.
    always_comb begin
        case (go_kind)
            OP_READ:  load_val = t_read;
            OP_PROG:  load_val = t_prog;
            OP_ERASE: load_val = t_erase;
            default:  load_val = t_reset;
        endcase
    end

    nand_busy_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(op_go), .kind_in(go_kind),
        .load_val(load_val), .op_fail(op_fail), .busy(busy), .fail(fail)
    );

    nand_resp_mux u_resp (
        .clk(clk), .rst_n(rst_n), .st_req(st_req), .other_req(other_req),
        .id_go(id_go), .re_stb(re_stb), .wp_n(wp_n), .busy(busy), .fail(fail),
        .mode(out_mode), .io_out(io_out)
    );

    assign rb_n = ~busy;

    // Back-end report: start pulse, operation code and abort flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_start <= 1'b0;
            op_kind  <= 3'd0;
            op_abort <= 1'b0;
        end else begin
            op_start <= op_go;
            if (op_go) op_kind <= go_kind;
            op_abort <= op_go && go_kind == OP_RESET && busy;
        end
    end

endmodule

// File: rtl/nand_fe_checker.sv
// Module: nand_fe_checker
// Property checks on the front-end's ports and output mode, attached to the
// top module by the bind at the end of this file.
module nand_fe_checker
    import nand_fe_pkg::*;
#(
    parameter int BUS_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cle,
    input logic             ale,
    input logic             we_stb,
    input logic             wp_n,
    input logic [BUS_W-1:0] io_in,
    input logic [7:0]       io_out,
    input logic             rb_n,
    input logic             op_start,
    input logic [2:0]       op_kind,
    input logic             op_abort,
    input out_mode_t        out_mode
);

    // R5: a reported start coincides with busy.
    assert_start_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |-> !rb_n);

    // R9: an abort is always reported together with a reset start.
    assert_abort_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        op_abort |-> (op_start && op_kind == 3'd4));

    // R10: while busy, nothing but a reset command can start an operation.
    assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rb_n && we_stb && !(cle && !ale && io_in[7:0] == 8'hFF)) |=> !op_start);

    // R3: status mode shows write-protect, ready and zero reserved bits.
    assert_status_layout_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_mode == OUT_STATUS) |-> (io_out[7] == wp_n && io_out[6] == rb_n && io_out[5:1] == 5'd0));

    // R2: with no query active the output byte is zero.
    assert_idle_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_mode == OUT_NONE) |-> io_out == 8'h00);

    // R12: a cycle with both latch inputs high starts nothing.
    assert_both_latch_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (we_stb && cle && ale) |=> !op_start);

    if (BUS_W > 8) begin : g_upper
        // R12: a non-zero upper byte voids a command or address cycle.
        assert_upper_byte_R12: assert property (@(posedge clk) disable iff (!rst_n)
            (we_stb && (cle || ale) && io_in[BUS_W-1:8] != '0) |=> !op_start);
    end

endmodule

bind nand_cmd_frontend nand_fe_checker #(.BUS_W(BUS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cle(cle), .ale(ale), .we_stb(we_stb),
    .wp_n(wp_n), .io_in(io_in), .io_out(io_out), .rb_n(rb_n),
    .op_start(op_start), .op_kind(op_kind), .op_abort(op_abort),
    .out_mode(out_mode)
);

// File: tb/nand_cmd_frontend_tb_top.sv
// Bench for nand_cmd_frontend: directed sequences mixed with seeded random
// addresses, busy lengths, results and unrecognised command bytes.
module nand_cmd_frontend_tb_top;

    localparam int BUS_W = 16;
    localparam int AB    = 4;
    localparam int CW    = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cle = 1'b0, ale = 1'b0, we_stb = 1'b0, re_stb = 1'b0;
    logic [15:0]   io_in = '0;
    logic          wp_n = 1'b1;
    logic [CW-1:0] t_read = 16'd3, t_prog = 16'd5, t_erase = 16'd6, t_reset = 16'd4;
    logic          op_fail = 1'b0;
    logic [7:0]    io_out;
    logic          rb_n, op_start, op_abort;
    logic [2:0]    op_kind;
    logic [31:0]   op_addr;

    int n_chk = 0;
    int n_fail = 0;
    logic exp_fail = 1'b0;

    always #10 clk = ~clk;

    nand_cmd_frontend #(.BUS_W(BUS_W), .ADDR_BYTES(AB), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cle(cle), .ale(ale), .we_stb(we_stb),
        .re_stb(re_stb), .io_in(io_in), .wp_n(wp_n), .t_read(t_read),
        .t_prog(t_prog), .t_erase(t_erase), .t_reset(t_reset), .op_fail(op_fail),
        .io_out(io_out), .rb_n(rb_n), .op_start(op_start), .op_kind(op_kind),
        .op_addr(op_addr), .op_abort(op_abort)
    );

    function automatic logic [7:0] exp_status(input logic wp, input logic rdy, input logic f);
        return {wp, rdy, 5'b0, f};
    endfunction

    function automatic logic [7:0] exp_id(input int i);
        case (i)
            0: return 8'hEC;
            1: return 8'h76;
            2: return 8'hA5;
            3: return 8'hC0;
            default: return 8'h00;
        endcase
    endfunction

    function automatic bit known_cmd(input logic [7:0] b);
        return b == 8'h00 || b == 8'h10 || b == 8'h60 || b == 8'h70 ||
               b == 8'h80 || b == 8'h90 || b == 8'hD0 || b == 8'hFF;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic c, input logic a, input logic [15:0] d);
        @(negedge clk);
        cle = c; ale = a; io_in = d; we_stb = 1'b1;
        @(negedge clk);
        cle = 1'b0; ale = 1'b0; io_in = '0; we_stb = 1'b0;
    endtask

    task automatic cmd(input logic [7:0] b);
        wr(1'b1, 1'b0, {8'h00, b});
    endtask

    task automatic adr(input logic [7:0] b);
        wr(1'b0, 1'b1, {8'h00, b});
    endtask

    task automatic rd_check(input string req, input logic [7:0] exp);
        check(req, {24'd0, io_out}, {24'd0, exp});
        re_stb = 1'b1;
        @(negedge clk);
        re_stb = 1'b0;
    endtask

    // Counts busy cycles starting at the current sample point.
    task automatic wait_busy(input string req, input int exp_n);
        int n = 0;
        while (rb_n == 1'b0 && n < 100000) begin
            n++;
            @(negedge clk);
        end
        if (exp_n >= 0) check(req, n, exp_n);
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL R10: watchdog expired, actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] a;
        int          n;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 rb_n", rb_n, 1);
        check("R1 io_out", io_out, 0);
        check("R1 op_start", op_start, 0);
        check("R1 op_abort", op_abort, 0);

        // R3: status after reset, persistent across reads
        cmd(8'h70);
        rd_check("R3 status", exp_status(1, 1, 0));
        rd_check("R3 persist", exp_status(1, 1, 0));
        rd_check("R1 fail clear", exp_status(1, 1, 0));

        // R2: identification sequence
        cmd(8'h90);
        check("R2 pre-address", io_out, 0);
        adr(8'h00);
        for (int i = 0; i < 5; i++) rd_check("R2 id byte", exp_id(i));

        // R5 / R4: programs with random address, length and result
        for (int k = 0; k < 4; k++) begin
            a = $urandom;
            n = (k == 3) ? 0 : int'($urandom_range(1, 20));
            t_prog = CW'(n);
            op_fail = (k == 0) ? 1'b1 : (k == 1) ? 1'b0 : 1'($urandom & 1);
            cmd(8'h80);
            for (int b = 0; b < 4; b++) adr(a[8*b +: 8]);
            wr(1'b0, 1'b0, 16'($urandom));
            wr(1'b0, 1'b0, 16'($urandom));
            cmd(8'h10);
            check("R5 start", op_start, 1);
            check("R5 kind", op_kind, 2);
            check("R5 addr", op_addr, a);
            wait_busy("R5 busy length", (n == 0) ? 1 : n);
            exp_fail = op_fail;
            cmd(8'h70);
            check("R4 fail after program", io_out, exp_status(1, 1, exp_fail));
        end

        // R6: erase, passing
        a = $urandom;
        t_erase = 16'd9;
        op_fail = 1'b0;
        cmd(8'h60);
        for (int b = 0; b < 3; b++) adr(a[8*b +: 8]);
        cmd(8'hD0);
        check("R6 kind", op_kind, 3);
        check("R6 addr", op_addr, {8'h00, a[23:0]});
        wait_busy("R6 busy length", 9);
        exp_fail = 1'b0;
        cmd(8'h70);
        check("R4 fail after erase", io_out, exp_status(1, 1, 0));

        // R7: read, with op_fail high that must not be captured (R4)
        a = $urandom;
        t_read = 16'd5;
        op_fail = 1'b1;
        cmd(8'h00);
        for (int b = 0; b < 3; b++) begin
            adr(a[8*b +: 8]);
            check("R7 no early start", op_start, 0);
        end
        adr(a[31:24]);
        check("R7 start", op_start, 1);
        check("R7 kind", op_kind, 1);
        check("R7 addr", op_addr, a);
        wait_busy("R7 busy length", 5);
        cmd(8'h70);
        check("R4 read keeps fail", io_out, exp_status(1, 1, 0));

        // R10: commands during busy
        t_prog = 16'd30;
        op_fail = 1'b1;
        cmd(8'h80);
        for (int b = 0; b < 4; b++) adr(8'h11);
        cmd(8'h10);
        cmd(8'h70);
        check("R10 status while busy", io_out, exp_status(1, 0, 0));
        cmd(8'h90);
        check("R10 ident ignored", op_start, 0);
        adr(8'h00);
        check("R10 still status", io_out, exp_status(1, 0, 0));
        cmd(8'h00);
        for (int b = 0; b < 4; b++) adr(8'h22);
        check("R10 read ignored", op_start, 0);
        wait_busy("R10", -1);
        check("R10 status after busy", io_out, exp_status(1, 1, 1));

        // R8: reset while ready clears fail
        t_reset = 16'd7;
        cmd(8'hFF);
        check("R8 kind", op_kind, 4);
        check("R8 no abort", op_abort, 0);
        wait_busy("R8 busy length", 7);
        cmd(8'h70);
        check("R8 fail cleared", io_out, exp_status(1, 1, 0));

        // R9: reset during erase
        t_erase = 16'd40;
        op_fail = 1'b1;
        cmd(8'h60);
        for (int b = 0; b < 3; b++) adr(8'h33);
        cmd(8'hD0);
        cmd(8'hFF);
        check("R9 abort", op_abort, 1);
        check("R9 start", op_start, 1);
        check("R9 kind", op_kind, 4);
        wait_busy("R9 busy length", 7);
        cmd(8'h70);
        check("R9 no fail recorded", io_out, exp_status(1, 1, 0));

        // R9 / R4: reset lands on the last busy cycle of a failing program
        t_prog = 16'd2;
        cmd(8'h80);
        for (int b = 0; b < 4; b++) adr(8'h44);
        cmd(8'h10);
        cmd(8'hFF);
        check("R9 abort on last cycle", op_abort, 1);
        wait_busy("R9 reset interval", 7);
        cmd(8'h70);
        check("R4 reset wins over capture", io_out, exp_status(1, 1, 0));

        // R11: unknown and out-of-sequence bytes in status mode
        for (int k = 0; k < 8; k++) begin
            logic [7:0] u;
            u = 8'($urandom);
            while (known_cmd(u)) u = 8'($urandom);
            cmd(u);
            check("R11 unknown dropped", io_out, exp_status(1, 1, 0));
            check("R11 no start", op_start, 0);
        end
        cmd(8'h10);
        cmd(8'hD0);
        check("R11 stray confirm", io_out, exp_status(1, 1, 0));
        check("R11 stray confirm start", op_start, 0);

        // R11: unknown byte keeps the signature position
        cmd(8'h90);
        adr(8'h00);
        rd_check("R11 id first", 8'hEC);
        cmd(8'h5A);
        rd_check("R11 id continues", 8'h76);

        // R12: non-zero upper byte and both latches high
        cmd(8'h70);
        wr(1'b1, 1'b0, 16'h0190);
        check("R12 upper byte cmd", io_out, exp_status(1, 1, 0));
        wr(1'b1, 1'b1, 16'h0090);
        check("R12 both latches", io_out, exp_status(1, 1, 0));
        a = $urandom;
        t_read = 16'd2;
        cmd(8'h00);
        for (int b = 0; b < 3; b++) adr(a[8*b +: 8]);
        wr(1'b0, 1'b1, {8'h80, a[31:24]});
        check("R12 upper byte addr", op_start, 0);
        adr(a[31:24]);
        check("R12 good addr starts", op_start, 1);
        check("R12 addr value", op_addr, a);
        wait_busy("R7 short read", 2);

        // R3: write-protect bit
        wp_n = 1'b0;
        cmd(8'h70);
        check("R3 write protect", io_out, exp_status(0, 1, 0));
        wp_n = 1'b1;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule